// File: doc/BRIEF.md
# Pulse-Per-Second Time Counter

This block keeps the system time of a timing node as a whole-seconds count and a sub-second cycle count. The sub-second count advances once per cycle of the reference clock. With the default 62.5 MHz reference, each step is 16 ns and one second takes 62,500,000 cycles. Each time the sub-second count takes the value zero, the block starts a one-pulse-per-second output. The pulse lasts for a number of cycles that software programs.

Software changes the time in one of two ways. A set request overwrites both counts on the next clock edge. An adjust request stores a signed pair of offsets and applies them at the next second boundary. At that boundary the offsets are added to the values the counters would otherwise take, which are (seconds+1, 0). A busy flag covers the wait, and a one-cycle done flag marks the cycle in which the adjusted values appear. A snapshot strobe copies both counts together into output registers, so software always reads a consistent pair.

Top module: `pps_time_counter`

## Requirements
- R1: After reset both counts are 0, the snapshot outputs are 0, and `pps`, `adj_busy` and `adj_done` are low.
- R2: With no request, the sub-second count steps 0, 1, …, CYCLES_PER_SEC-1 and then returns to 0. That return adds 1 to the seconds count, which wraps from all ones to 0 (modulo 2^SEC_W).
- R3: `pps` goes high in the first cycle in which the sub-second count holds 0, whether it got there by a wrap, a set or an adjust. It stays high for `pulse_len` consecutive cycles, with `pulse_len` sampled on that cycle's edge. A `pulse_len` of 0 gives no pulse. A new zero while a pulse is running restarts the pulse.
- R4: `set_stb` loads `set_sec` and `set_sub` into the counts, visible in the next cycle. `set_sub` must be below CYCLES_PER_SEC.
- R5: `adj_stb` stores `adj_sec` and `adj_sub`, both two's complement. `adj_busy` is high from the next cycle until the adjust is applied. Until then the counts run exactly as in R2.
- R6: In the edge that ends the second while an adjust is pending, the counts become seconds = old+1+adj_sec and sub = adj_sub. If adj_sub ≥ CYCLES_PER_SEC, it is reduced by CYCLES_PER_SEC and one more second is added. If adj_sub < 0, CYCLES_PER_SEC is added to it and one second is removed. adj_sub must lie between -(CYCLES_PER_SEC-1) and 2^NS_W-1.
- R7: In the cycle the adjusted values first appear, `adj_done` is high for exactly one cycle and `adj_busy` is low, unless a new adjust arrived in the apply cycle.
- R8: `set_stb` has priority. It cancels a pending adjust, discards an `adj_stb` in the same cycle, and wins over a boundary apply in the same cycle. After it, `adj_busy` and `adj_done` are low.
- R9: `snap_stb` copies the counts held in its own cycle into `snap_sec` and `snap_sub`, visible from the next cycle. Otherwise the snapshot holds.
- R10: An `adj_stb` while an adjust is pending replaces the stored offsets. Only the latest offsets are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| set_stb | input | 1 | Immediate time load request |
| set_sec | input | SEC_W | Seconds value to load |
| set_sub | input | NS_W | Sub-second cycle value to load |
| adj_stb | input | 1 | Deferred adjust request |
| adj_sec | input | SEC_W | Signed seconds offset |
| adj_sub | input | NS_W+1 | Signed sub-second cycle offset |
| pulse_len | input | NS_W | PPS high time in cycles (625,000 for 10 ms at default rate) |
| snap_stb | input | 1 | Latch both counts into the snapshot |
| snap_sec | output | SEC_W | Snapshot of seconds |
| snap_sub | output | NS_W | Snapshot of sub-second cycles |
| pps | output | 1 | One-pulse-per-second output |
| adj_busy | output | 1 | Adjust pending |
| adj_done | output | 1 | Adjust applied in the previous edge |

## Verification
The collision that matters is a set request in the same cycle as the boundary that would apply a pending adjust. This may also coincide with a fresh adjust request. The bench runs to the last cycle of a second with an adjust pending, then raises set and adjust together. It expects the set values, no done flag, a cleared busy flag and a PPS start, and then an unadjusted next second. Random phases also let snapshot, set and adjust strobes fall on boundary cycles. Every cycle is compared against a cycle-accurate bench model.

// File: rtl/pps_time_pkg.sv
// Package: shared type for the pulse-per-second time counter.
// Assumes: nothing beyond IEEE 1800-2017.
package pps_time_pkg;

    // Which update the counters take on the coming edge.
    typedef enum logic [1:0] {
        UPD_RUN = 2'd0,
        UPD_SET = 2'd1,
        UPD_ADJ = 2'd2
    } upd_kind_e;

endpackage

// File: rtl/pps_adj_pending.sv
// Module: holds a deferred adjust request and decides when it is applied.
// Assumes: at_last is high in the last cycle of each second; set_stb
// has priority over everything held here.
module pps_adj_pending #(
    parameter int CYCLES_PER_SEC = 62_500_000,
    parameter int SEC_W          = 40,
    parameter int NS_W           = $clog2(CYCLES_PER_SEC)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   set_stb,
    input  logic                   adj_stb,
    input  logic [SEC_W-1:0]       adj_sec,
    input  logic signed [NS_W:0]   adj_sub,
    input  logic                   at_last,
    output logic                   apply,
    output logic [SEC_W-1:0]       pend_sec,
    output logic signed [NS_W:0]   pend_sub,
    output logic                   busy,
    output logic                   done
);
    localparam logic signed [NS_W:0] NEG_LIMIT = -$signed((NS_W+1)'(CYCLES_PER_SEC - 1));

    // Apply only at a boundary with a request held and no overriding set.
    assign apply = busy && at_last && !set_stb;

    // Track the pending offsets, the busy flag and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            done     <= 1'b0;
            pend_sec <= '0;
            pend_sub <= '0;
        end else if (set_stb) begin
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= apply;
            if (adj_stb) begin
                pend_sec <= adj_sec;
                pend_sub <= adj_sub;
                busy     <= 1'b1;
            end else if (apply) begin
                busy <= 1'b0;
            end
        end
    end

    // R8: a set request leaves nothing pending and no done pulse.
    a_r8_set_cancels: assert property (@(posedge clk) disable iff (!rst_n)
        set_stb |=> !busy && !done);

    // R5: without a boundary, set or new request, the pending state holds.
    a_r5_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !at_last && !set_stb && !adj_stb |=> busy && $stable(pend_sec) && $stable(pend_sub));

    // R7: every apply yields a one-cycle done flag.
    a_r7_done_after_apply: assert property (@(posedge clk) disable iff (!rst_n)
        apply |=> done);

    // R6: adjust offsets must lie in the supported range.
    a_r6_adj_range: assert property (@(posedge clk) disable iff (!rst_n)
        adj_stb |-> adj_sub >= NEG_LIMIT);

endmodule

// File: rtl/pps_time_core.sv
// Module: seconds and sub-second counters with set and adjust updates.
// Assumes: set_sub is below CYCLES_PER_SEC; pend_sub lies between
// -(CYCLES_PER_SEC-1) and 2^NS_W-1, so one carry or borrow suffices.
module pps_time_core
    import pps_time_pkg::*;
#(
    parameter int CYCLES_PER_SEC = 62_500_000,
    parameter int SEC_W          = 40,
    parameter int NS_W           = $clog2(CYCLES_PER_SEC)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   set_stb,
    input  logic [SEC_W-1:0]       set_sec,
    input  logic [NS_W-1:0]        set_sub,
    input  logic                   apply,
    input  logic [SEC_W-1:0]       pend_sec,
    input  logic signed [NS_W:0]   pend_sub,
    output logic [SEC_W-1:0]       sec_q,
    output logic [NS_W-1:0]        sub_q,
    output logic                   at_last,
    output logic                   zero_next
);
    localparam logic [NS_W-1:0]          LAST  = NS_W'(CYCLES_PER_SEC - 1);
    localparam logic signed [NS_W+1:0]   PER_S = $signed((NS_W+2)'(CYCLES_PER_SEC));

    upd_kind_e               kind;
    logic [SEC_W-1:0]        sec_d;
    logic [NS_W-1:0]         sub_d;
    logic signed [NS_W+1:0]  sub_ext;
    logic signed [NS_W+1:0]  sub_fix;
    logic [SEC_W-1:0]        sec_adj;

    assign at_last = (sub_q == LAST);

    // Choose the update kind; set wins over a boundary apply.
    always_comb begin
        if (set_stb)    kind = UPD_SET;
        else if (apply) kind = UPD_ADJ;
        else            kind = UPD_RUN;
    end

    // Normalise the signed sub-second offset with one carry or borrow.
    always_comb begin
        sub_ext = {pend_sub[NS_W], pend_sub};
        sec_adj = sec_q + SEC_W'(1) + pend_sec;
        if (sub_ext >= PER_S) begin
            sub_fix = sub_ext - PER_S;
            sec_adj = sec_adj + SEC_W'(1);
        end else if (sub_ext < 0) begin
            sub_fix = sub_ext + PER_S;
            sec_adj = sec_adj - SEC_W'(1);
        end else begin
            sub_fix = sub_ext;
        end
    end

    // Next counter values for each update kind.
    always_comb begin
        case (kind)
            UPD_SET: begin
                sec_d = set_sec;
                sub_d = set_sub;
            end
            UPD_ADJ: begin
                sec_d = sec_adj;
                sub_d = NS_W'(sub_fix);
            end
            default: begin
                sec_d = at_last ? sec_q + SEC_W'(1) : sec_q;
                sub_d = at_last ? '0 : sub_q + NS_W'(1);
            end
        endcase
    end

    assign zero_next = (sub_d == '0);

    // Counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q <= '0;
            sub_q <= '0;
        end else begin
            sec_q <= sec_d;
            sub_q <= sub_d;
        end
    end

    // R2: the sub-second count never leaves its range.
    a_r2_sub_range: assert property (@(posedge clk) disable iff (!rst_n)
        sub_q <= LAST);

    // R2: a plain boundary wraps to zero and adds one second.
    a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        at_last && !set_stb && !apply |=> sub_q == '0 && sec_q == $past(sec_q) + SEC_W'(1));

    // R4: a set request shows its values in the next cycle.
    a_r4_set_load: assert property (@(posedge clk) disable iff (!rst_n)
        set_stb |=> sec_q == $past(set_sec) && sub_q == $past(set_sub));

    // R4: the loaded sub-second value must be in range.
    a_r4_set_sub_range: assert property (@(posedge clk) disable iff (!rst_n)
        set_stb |-> set_sub <= LAST);

    // R6: a zero sub-second offset lands exactly on the new second plus offset.
    a_r6_apply_whole: assert property (@(posedge clk) disable iff (!rst_n)
        apply && !set_stb && pend_sub == '0 |=> sub_q == '0 &&
        sec_q == $past(sec_q) + SEC_W'(1) + $past(pend_sec));

endmodule

// File: rtl/pps_pulse_gen.sv
// Module: stretches each second start into a programmable-width pulse.
// Assumes: start is high on the edge that loads zero into the
// sub-second counter; pulse_len is sampled on that edge.
module pps_pulse_gen #(
    parameter int NS_W = 26
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [NS_W-1:0] pulse_len,
    output logic            pps
);
    logic [NS_W-1:0] remain;

    // Load the remaining width at a start, then count it down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pps    <= 1'b0;
            remain <= '0;
        end else if (start) begin
            pps    <= (pulse_len != '0);
            remain <= (pulse_len != '0) ? pulse_len - NS_W'(1) : '0;
        end else if (remain != '0) begin
            pps    <= 1'b1;
            remain <= remain - NS_W'(1);
        end else begin
            pps <= 1'b0;
        end
    end

    // R3: a start with a non-zero width raises the output.
    a_r3_pps_start: assert property (@(posedge clk) disable iff (!rst_n)
        start && pulse_len != '0 |=> pps);

    // R3: the output only rises because of a start.
    a_r3_pps_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pps) |-> $past(start));

endmodule

// File: rtl/pps_snapshot.sv
// Module: captures both counts together on a strobe.
// Assumes: the counts presented are those held in the strobe cycle.
module pps_snapshot #(
    parameter int SEC_W = 40,
    parameter int NS_W  = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             snap_stb,
    input  logic [SEC_W-1:0] sec_in,
    input  logic [NS_W-1:0]  sub_in,
    output logic [SEC_W-1:0] snap_sec,
    output logic [NS_W-1:0]  snap_sub
);
    // Copy both fields in the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_sec <= '0;
            snap_sub <= '0;
        end else if (snap_stb) begin
            snap_sec <= sec_in;
            snap_sub <= sub_in;
        end
    end

    // R9: the snapshot matches the counts of the strobe cycle.
    a_r9_snap_pair: assert property (@(posedge clk) disable iff (!rst_n)
        snap_stb |=> snap_sec == $past(sec_in) && snap_sub == $past(sub_in));

    // R9: without a strobe the snapshot holds.
    a_r9_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_stb |=> $stable(snap_sec) && $stable(snap_sub));

endmodule

// File: rtl/pps_time_counter.sv
// Module: top of the pulse-per-second time counter.
// Assumes: one reference clock domain; requests arrive as one-cycle
// strobes with their data valid in the same cycle.
module pps_time_counter #(
    parameter int CYCLES_PER_SEC = 62_500_000,
    parameter int SEC_W          = 40,
    parameter int NS_W           = $clog2(CYCLES_PER_SEC)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 set_stb,
    input  logic [SEC_W-1:0]     set_sec,
    input  logic [NS_W-1:0]      set_sub,
    input  logic                 adj_stb,
    input  logic [SEC_W-1:0]     adj_sec,
    input  logic [NS_W:0]        adj_sub,
    input  logic [NS_W-1:0]      pulse_len,
    input  logic                 snap_stb,
    output logic [SEC_W-1:0]     snap_sec,
    output logic [NS_W-1:0]      snap_sub,
    output logic                 pps,
    output logic                 adj_busy,
    output logic                 adj_done
);
    logic                  apply;
    logic                  at_last;
    logic                  zero_next;
    logic [SEC_W-1:0]      pend_sec;
    logic signed [NS_W:0]  pend_sub;
    logic [SEC_W-1:0]      sec_q;
    logic [NS_W-1:0]       sub_q;

    pps_adj_pending #(.CYCLES_PER_SEC(CYCLES_PER_SEC), .SEC_W(SEC_W), .NS_W(NS_W)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_stb  (set_stb),
        .adj_stb  (adj_stb),
        .adj_sec  (adj_sec),
        .adj_sub  ($signed(adj_sub)),
        .at_last  (at_last),
        .apply    (apply),
        .pend_sec (pend_sec),
        .pend_sub (pend_sub),
        .busy     (adj_busy),
        .done     (adj_done)
    );

    pps_time_core #(.CYCLES_PER_SEC(CYCLES_PER_SEC), .SEC_W(SEC_W), .NS_W(NS_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_stb   (set_stb),
        .set_sec   (set_sec),
        .set_sub   (set_sub),
        .apply     (apply),
        .pend_sec  (pend_sec),
        .pend_sub  (pend_sub),
        .sec_q     (sec_q),
        .sub_q     (sub_q),
        .at_last   (at_last),
        .zero_next (zero_next)
    );

    pps_pulse_gen #(.NS_W(NS_W)) u_pulse (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (zero_next),
        .pulse_len (pulse_len),
        .pps       (pps)
    );

    pps_snapshot #(.SEC_W(SEC_W), .NS_W(NS_W)) u_snap (
        .clk      (clk),
        .rst_n    (rst_n),
        .snap_stb (snap_stb),
        .sec_in   (sec_q),
        .sub_in   (sub_q),
        .snap_sec (snap_sec),
        .snap_sub (snap_sub)
    );

endmodule

// File: tb/pps_time_counter_test.sv
module pps_time_counter_test;
    localparam int CLK_PERIOD = 10;
    localparam int P          = 100;
    localparam int SW         = 40;
    localparam int NW         = $clog2(P);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic set_stb = 1'b0, adj_stb = 1'b0, snap_stb = 1'b0;
    logic [SW-1:0] set_sec = '0, adj_sec = '0;
    logic [NW-1:0] set_sub = '0, pulse_len = NW'(10);
    logic [NW:0]   adj_sub = '0;
    logic [SW-1:0] snap_sec;
    logic [NW-1:0] snap_sub;
    logic pps, adj_busy, adj_done;

    int checks = 0, fails = 0;
    bit finished = 1'b0;

    // Bench model state.
    logic [SW-1:0] m_sec, m_asec, e_ssec;
    int m_sub, m_asub, e_ssub, m_rem;
    bit m_busy, e_done, m_pps;

    always #(CLK_PERIOD/2) clk = ~clk;

    pps_time_counter #(.CYCLES_PER_SEC(P), .SEC_W(SW)) uut (
        .clk(clk), .rst_n(rst_n),
        .set_stb(set_stb), .set_sec(set_sec), .set_sub(set_sub),
        .adj_stb(adj_stb), .adj_sec(adj_sec), .adj_sub(adj_sub),
        .pulse_len(pulse_len), .snap_stb(snap_stb),
        .snap_sec(snap_sec), .snap_sub(snap_sub),
        .pps(pps), .adj_busy(adj_busy), .adj_done(adj_done)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // One edge of the reference model, applied to the current inputs.
    task automatic model_step();
        int t;
        logic [SW-1:0] s;
        if (snap_stb) begin e_ssec = m_sec; e_ssub = m_sub; end
        if (set_stb) begin
            m_sec = set_sec; m_sub = int'(set_sub); m_busy = 0; e_done = 0;
        end else if (m_sub == P-1 && m_busy) begin
            t = m_asub; s = m_sec + SW'(1) + m_asec;
            if (t >= P) begin t -= P; s = s + SW'(1); end
            else if (t < 0) begin t += P; s = s - SW'(1); end
            m_sec = s; m_sub = t; e_done = 1;
            if (adj_stb) begin m_asec = adj_sec; m_asub = int'($signed(adj_sub)); end
            else m_busy = 0;
        end else begin
            if (m_sub == P-1) begin m_sub = 0; m_sec = m_sec + SW'(1); end
            else m_sub++;
            e_done = 0;
            if (adj_stb) begin m_asec = adj_sec; m_asub = int'($signed(adj_sub)); m_busy = 1; end
        end
        if (m_sub == 0) begin
            m_pps = (pulse_len != 0);
            m_rem = (pulse_len != 0) ? int'(pulse_len) - 1 : 0;
        end else if (m_rem != 0) begin
            m_rem--; m_pps = 1;
        end else m_pps = 0;
    endtask

    task automatic cycle();
        model_step();
        @(posedge clk);
        @(negedge clk);
        set_stb = 0; adj_stb = 0; snap_stb = 0;
        check("R3 pps", pps, m_pps);
        check("R5 adj_busy", adj_busy, m_busy);
        check("R7 adj_done", adj_done, e_done);
        check("R9 snap_sec", snap_sec, e_ssec);
        check("R9 snap_sub", snap_sub, e_ssub);
    endtask

    task automatic do_set(input logic [SW-1:0] s, input int sub);
        set_stb = 1; set_sec = s; set_sub = NW'(sub); cycle();
    endtask

    task automatic do_adj(input logic [SW-1:0] s, input int sub);
        adj_stb = 1; adj_sec = s; adj_sub = (NW+1)'(sub); cycle();
    endtask

    task automatic snap_now();
        snap_stb = 1; cycle();
    endtask

    task automatic run_to_last();
        while (m_sub != P-1) cycle();
    endtask

    task automatic count_pps(input int exp, input string req);
        int cnt = 0;
        for (int i = 0; i < 20; i++) begin
            if (pps) cnt++;
            cycle();
        end
        check(req, cnt, exp);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        m_sec = '0; m_asec = '0; e_ssec = '0;
        m_sub = 0; m_asub = 0; e_ssub = 0; m_rem = 0;
        m_busy = 0; e_done = 0; m_pps = 0;
        // R1 reset state
        check("R1 pps", pps, 0);
        check("R1 busy", adj_busy, 0);
        check("R1 done", adj_done, 0);
        check("R1 snap_sec", snap_sec, 0);
        check("R1 snap_sub", snap_sub, 0);

        // R4 immediate set
        do_set(SW'(5), 20);
        snap_now();
        check("R4 set sec", snap_sec, 5);
        check("R4 set sub", snap_sub, 20);

        // R2 seconds wrap from all ones, R3 pulse on wrap
        do_set('1, 98);
        cycle(); cycle();
        check("R3 pps at zero", pps, 1);
        snap_now();
        check("R2 sec wrap", snap_sec, 0);
        check("R2 sub wrap", snap_sub, 0);

        // R6 borrow, R5 busy, R7 done
        do_set(SW'(10), 50);
        do_adj(SW'(3), -30);
        run_to_last();
        check("R5 busy before boundary", adj_busy, 1);
        cycle();
        check("R7 done", adj_done, 1);
        check("R7 busy cleared", adj_busy, 0);
        snap_now();
        check("R6 borrow sec", snap_sec, 13);
        check("R6 borrow sub", snap_sub, 70);

        // R6 carry with negative seconds offset
        do_adj(-SW'(2), 105);
        run_to_last();
        cycle();
        snap_now();
        check("R6 carry sec", snap_sec, 13);
        check("R6 carry sub", snap_sub, 5);

        // R8 set at the apply boundary, with an adjust in the same cycle
        do_adj(SW'(6), 0);
        run_to_last();
        set_stb = 1; set_sec = SW'(7); set_sub = '0;
        adj_stb = 1; adj_sec = SW'(9); adj_sub = (NW+1)'(9);
        cycle();
        check("R8 busy cancelled", adj_busy, 0);
        check("R8 no done", adj_done, 0);
        check("R3 pps on set to zero", pps, 1);
        snap_now();
        check("R8 set sec", snap_sec, 7);
        run_to_last();
        cycle();
        snap_now();
        check("R8 next second unadjusted", snap_sec, 8);
        check("R8 next sub", snap_sub, 0);

        // R10 latest adjust wins
        do_adj(SW'(1), 0);
        do_adj(SW'(4), 0);
        run_to_last();
        cycle();
        snap_now();
        check("R10 replaced offset", snap_sec, 13);

        // R3 pulse widths
        pulse_len = NW'(3);
        run_to_last(); cycle();
        count_pps(3, "R3 width 3");
        pulse_len = '0;
        run_to_last(); cycle();
        count_pps(0, "R3 width 0");

        // Random phase against the model
        for (int i = 0; i < 3000; i++) begin
            int r = int'($urandom % 1000);
            snap_stb = r[0];
            if (r % 97 == 0) begin
                set_stb = 1; set_sec = {$urandom, $urandom};
                set_sub = NW'($urandom % P);
            end
            if (r % 41 == 0) begin
                adj_stb = 1; adj_sec = SW'(int'($urandom % 7) - 3);
                adj_sub = (NW+1)'(int'($urandom % 227) - 99);
            end
            if (r % 211 == 0) pulse_len = NW'($urandom % 120);
            cycle();
        end

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end
endmodule